// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block handles character framing for an asynchronous serial link, in both directions. A single enable pulse, `os_tick`, arrives sixteen times per bit period, and both directions run from it. Baud generation is outside the block.

The transmitter takes one byte at a time through a ready/valid handshake. It sends the byte on `tx_line` as follows:

- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional parity bit;
- one or two high stop bits.

The receiver passes the serial input through a synchronizer and looks for a falling edge. It confirms the start bit at half a bit period and samples every later bit at its centre. It hands each character up as a one-cycle pulse, together with a parity-error flag, a framing-error flag and a break flag.

Software-visible registers, FIFOs and modem or flow-control signals are not part of this block. The surrounding logic drives the configuration inputs directly.

Top module: `uart_frame_engine`

## Requirements
- R1: The idle line level is high and the start bit is low. Data goes out least significant bit first. The number of data bits follows `cfg_len`: code 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5.
- R2: `cfg_stop` equal to 1 selects two high stop bits, and any other code selects one. The receiver checks only the first stop bit.
- R3: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd` = 0 the parity is even: the parity bit is the XOR of the data bits. With `cfg_par_odd` = 1 it is the inverse of that XOR. When `cfg_par_en` is 0, no parity bit is sent or expected.
- R4: `tx_ready` is high only while `tx_en` is 1 and no character is in flight. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The start bit appears on the cycle after that edge. Every bit lasts 16 `os_tick` pulses. The configuration is captured when the byte is taken.
- R5: `tx_busy` rises with acceptance and stays high until the last stop bit ends. Clearing `tx_en` during a character does not shorten it.
- R6: The receiver raises `rx_valid` for exactly one cycle, at the centre of the first stop bit. `rx_data` holds the character. Bits above the configured length are zero.
- R7: `rx_par_err` is 1 when parity is enabled and the received parity bit differs from the value that R3 gives for the received data.
- R8: `rx_frm_err` is 1 when the first stop bit is sampled low. `rx_break` is 1 when, in addition, all received data bits are zero.
- R9: A character starts only on a low level that follows a high level seen since the last character or since enable. If the line is high again half a bit after detection, the start is discarded and no character is delivered.
- R10: While `rx_en` is 0, the receiver is idle and `rx_valid` stays low. A character in progress when `rx_en` is cleared is dropped.
- R11: During reset and on the first cycle after it, `tx_line` is high and `tx_busy` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| cfg_len | input | 2 | Data length code (0:8, 1:7, 2:6, 3:5 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop | input | 2 | Stop length code (1: two bits, other: one) |
| tx_en | input | 1 | Transmitter accepts new bytes |
| rx_en | input | 1 | Receiver enable |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | A character is being shifted out |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle pulse with a received character |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | First stop bit was low |
| rx_break | output | 1 | Framing error with all-zero data |

## Verification
The hardest receiver situations to reach from the ports are three:

- a start pulse shorter than half a bit;
- a line that stays low after a framing error;
- re-enabling the receiver while the line is in the middle of a character.

Each needs the serial input held for an exact number of ticks. The bench therefore drives `rx_line` itself, with bit lengths counted in oversampling periods. It sends a four-tick low glitch, all-zero characters with a low stop bit, and a character whose enable is removed and restored partway through. It then checks that only the characters it expects come out.

On the transmit side, a behavioural model made of bit queues predicts `tx_line`, `tx_busy` and `tx_ready` on every clock. The stimulus includes configuration changes during a character and `tx_en` changes during a character.

// File: rtl/uart_fe_pkg.sv
// Package: shared types and helpers for the serial frame engine.
// Assumes characters are at most CHAR_W bits; the length code subtracts from CHAR_W.
package uart_fe_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned IDX_W  = $clog2(CHAR_W + 1);
    localparam int unsigned SEL_W  = $clog2(CHAR_W);

    // Frame settings as seen by the transmitter.
    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

    // Position within a character, shared by both directions.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // Number of data bits for a length code (0 gives the longest).
    function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] code);
        return IDX_W'(CHAR_W) - IDX_W'(code);
    endfunction

    // Parity bit over the low n bits of d; odd inverts the even result.
    function automatic logic par_of(input logic [CHAR_W-1:0] d,
                                    input logic [IDX_W-1:0]  n,
                                    input logic              odd);
        logic acc;
        acc = odd;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(n)) acc = acc ^ d[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/uart_fe_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial input.
// Assumes the input is slow compared with clk; resets to RST_VAL (idle level).
module uart_fe_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic stage;
            // Single retiming flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= RST_VAL;
                else        stage <= d;
            end
            assign q = stage;
        end else begin : g_chain
            logic [STAGES-1:0] pipe;
            // Shift the input through the chain of flops.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], d};
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/uart_fe_tx.sv
// Module: character serializer.
// Takes one byte per handshake, captures the frame settings at that moment,
// and emits start, data (LSB first), optional parity and stop bits, each OSR ticks long.
// Assumes os_tick is a one-cycle enable at OSR times the bit rate.
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              tx_en,
    input  frame_cfg_t        cfg,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line,
    output logic              busy
);

    localparam int unsigned     CNT_W    = $clog2(OSR);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [CHAR_W-1:0] shreg;
    logic [IDX_W-1:0]  sent;
    logic [IDX_W-1:0]  nbits;
    logic              par_q;
    logic              par_en_q;
    logic              two_q;
    logic              extra_stop;
    logic              take;

    assign in_ready = tx_en && (ph == PH_IDLE);
    assign take     = in_valid && in_ready;
    assign busy     = (ph != PH_IDLE);

    // Frame sequencer: load on handshake, advance one bit every OSR ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            sent       <= '0;
            nbits      <= '0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            two_q      <= 1'b0;
            extra_stop <= 1'b0;
            line       <= 1'b1;
        end else if (take) begin
            ph       <= PH_START;
            cnt      <= '0;
            line     <= 1'b0;
            shreg    <= in_data;
            nbits    <= char_bits(cfg.len_code);
            par_q    <= par_of(in_data, char_bits(cfg.len_code), cfg.par_odd);
            par_en_q <= cfg.par_en;
            two_q    <= cfg.two_stop;
        end else if (ph != PH_IDLE && os_tick) begin
            if (cnt != CNT_LAST) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                unique case (ph)
                    PH_START: begin
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                        sent  <= IDX_W'(1);
                        ph    <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (sent == nbits) begin
                            if (par_en_q) begin
                                line <= par_q;
                                ph   <= PH_PAR;
                            end else begin
                                line       <= 1'b1;
                                extra_stop <= two_q;
                                ph         <= PH_STOP;
                            end
                        end else begin
                            line  <= shreg[0];
                            shreg <= shreg >> 1;
                            sent  <= sent + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        line       <= 1'b1;
                        extra_stop <= two_q;
                        ph         <= PH_STOP;
                    end
                    PH_STOP: begin
                        if (extra_stop) extra_stop <= 1'b0;
                        else            ph         <= PH_IDLE;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!line && busy)); // R4
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line); // R1
    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STOP) |-> line); // R2
    AST_TX_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !os_tick) |=> $stable(line)); // R4

endmodule

// File: rtl/uart_fe_rx.sv
// Module: character deserializer.
// Detects a falling edge on the synchronized line, confirms the start bit at
// half a bit, samples each later bit at its centre and reports the character
// with parity, framing and break flags at the centre of the first stop bit.
// Assumes line_s is already synchronized and os_tick runs at OSR times the bit rate.
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              line_s,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_par_err,
    output logic              out_frm_err,
    output logic              out_break
);

    localparam int unsigned      CNT_W    = $clog2(OSR);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [CHAR_W-1:0] sh;
    logic [IDX_W-1:0]  got;
    logic [IDX_W-1:0]  nbits_q;
    logic              par_en_q;
    logic              par_odd_q;
    logic              par_rx;
    logic              armed;

    // Receive sequencer: edge detect, start confirmation, centre sampling, delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph          <= PH_IDLE;
            cnt         <= '0;
            sh          <= '0;
            got         <= '0;
            nbits_q     <= '0;
            par_en_q    <= 1'b0;
            par_odd_q   <= 1'b0;
            par_rx      <= 1'b0;
            armed       <= 1'b0;
            out_data    <= '0;
            out_valid   <= 1'b0;
            out_par_err <= 1'b0;
            out_frm_err <= 1'b0;
            out_break   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (!rx_en) begin
                ph    <= PH_IDLE;
                cnt   <= '0;
                armed <= 1'b0;
            end else if (os_tick) begin
                unique case (ph)
                    PH_IDLE: begin
                        if (line_s) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            ph        <= PH_START;
                            cnt       <= '0;
                            sh        <= '0;
                            got       <= '0;
                            nbits_q   <= char_bits(len_code);
                            par_en_q  <= par_en;
                            par_odd_q <= par_odd;
                        end
                    end
                    PH_START: begin
                        if (cnt == CNT_HALF) begin
                            cnt <= '0;
                            ph  <= line_s ? PH_IDLE : PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt                 <= '0;
                            sh[got[SEL_W-1:0]]  <= line_s;
                            got                 <= got + 1'b1;
                            if (got == nbits_q - 1'b1)
                                ph <= par_en_q ? PH_PAR : PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (cnt == CNT_LAST) begin
                            cnt    <= '0;
                            par_rx <= line_s;
                            ph     <= PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (cnt == CNT_LAST) begin
                            cnt         <= '0;
                            out_valid   <= 1'b1;
                            out_data    <= sh;
                            out_frm_err <= !line_s;
                            out_break   <= !line_s && (sh == '0);
                            out_par_err <= par_en_q &&
                                           (par_rx != par_of(sh, nbits_q, par_odd_q));
                            armed       <= line_s;
                            ph          <= PH_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_RX_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(ph) == PH_STOP)); // R6
    AST_RX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !out_valid); // R10
    AST_RX_HIGH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && os_tick && line_s) |=> (ph == PH_IDLE)); // R9

endmodule

// File: rtl/uart_frame_engine.sv
// Module: top of the serial frame engine.
// Ties the serializer, the input synchronizer and the deserializer to one set
// of frame settings. Assumes os_tick is a single-cycle pulse at OSR times the bit rate.
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    output logic              tx_busy,
    input  logic              rx_line,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_break
);

    frame_cfg_t tx_cfg;
    logic       rx_sync;

    assign tx_cfg = '{len_code: cfg_len,
                      par_en:   cfg_par_en,
                      par_odd:  cfg_par_odd,
                      two_stop: (cfg_stop == 2'd1)};

    uart_fe_tx #(.OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .tx_en    (tx_en),
        .cfg      (tx_cfg),
        .in_data  (tx_data),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .line     (tx_line),
        .busy     (tx_busy)
    );

    uart_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_sync)
    );

    uart_fe_rx #(.OSR(OSR)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_en       (rx_en),
        .len_code    (cfg_len),
        .par_en      (cfg_par_en),
        .par_odd     (cfg_par_odd),
        .line_s      (rx_sync),
        .out_data    (rx_data),
        .out_valid   (rx_valid),
        .out_par_err (rx_par_err),
        .out_frm_err (rx_frm_err),
        .out_break   (rx_break)
    );

    AST_BREAK_NEEDS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_frm_err && rx_data == '0)); // R8

endmodule

// File: tb/uart_frame_engine_bench.sv
// Bench: a queue-based behavioural model predicts the transmit pins on every
// clock; the receive side is driven with frames built from the requirements.
module uart_frame_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int BIT_CLKS   = OSR * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       tx_en = 1'b1;
    logic       rx_en = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, tx_line, tx_busy;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frm_err, rx_break;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    int  tdiv   = 0;

    typedef struct {
        logic [7:0] d;
        bit         pe;
        bit         fe;
        bit         brk;
    } rx_exp_t;

    rx_exp_t rxq[$];
    int      fb[$];
    int      mq[$];
    int      mcnt = 0;

    uart_frame_engine u_uart_frame_engine (
        .clk (clk), .rst_n (rst_n), .os_tick (os_tick),
        .cfg_len (cfg_len), .cfg_par_en (cfg_par_en), .cfg_par_odd (cfg_par_odd),
        .cfg_stop (cfg_stop), .tx_en (tx_en), .rx_en (rx_en),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
        .tx_line (tx_line), .tx_busy (tx_busy), .rx_line (rx_line),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err), .rx_break (rx_break)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oversampling tick, one clock in TICK_DIV, driven away from the active edge.
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % TICK_DIV;
        os_tick = (tdiv == 0);
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails < 25) $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Bit list for one frame: start, data LSB first, parity, stop(s).  R1 R2 R3
    function automatic void build(input logic [7:0] d, input logic [1:0] lc,
                                  input logic pe, input logic odd, input logic two,
                                  input bit flip, input bit stop_lo);
        int n;
        bit p;
        n = 8 - int'(lc);
        p = odd;
        fb.delete();
        fb.push_back(0);
        for (int i = 0; i < n; i++) begin
            fb.push_back(int'(d[i]));
            p = p ^ d[i];
        end
        if (pe) fb.push_back(int'(p ^ flip));
        fb.push_back(stop_lo ? 0 : 1);
        if (two) fb.push_back(1);
    endfunction

    // Transmit reference model: one queue entry per bit, OSR ticks each.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mcnt = 0;
        end else if (mq.size() == 0) begin
            if (tx_valid && tx_en) begin
                build(tx_data, cfg_len, cfg_par_en, cfg_par_odd, cfg_stop == 2'd1, 0, 0);
                mq   = fb;
                mcnt = 0;
            end
        end else if (os_tick) begin
            mcnt++;
            if (mcnt == OSR) begin
                mcnt = 0;
                void'(mq.pop_front());
            end
        end
    end

    // Per-clock comparison and receive scoreboard, a quarter period after the edge.
    always @(posedge clk) begin
        int      exp_line;
        rx_exp_t e;
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            exp_line = (mq.size() != 0) ? mq[0] : 1;
            chk(tx_line === exp_line[0], "R1 R2 R3 tx_line", int'(tx_line), exp_line);
            chk(tx_busy === (mq.size() != 0), "R5 tx_busy", int'(tx_busy), int'(mq.size() != 0));
            chk(tx_ready === (tx_en && mq.size() == 0), "R4 tx_ready",
                int'(tx_ready), int'(tx_en && mq.size() == 0));
            if (rx_valid) begin
                if (rxq.size() == 0) begin
                    chk(0, "R9 R10 unexpected rx_valid", int'(rx_data), 0);
                end else begin
                    e = rxq.pop_front();
                    chk(rx_data === e.d, "R6 rx_data", int'(rx_data), int'(e.d));
                    chk(rx_par_err === e.pe, "R7 rx_par_err", int'(rx_par_err), int'(e.pe));
                    chk(rx_frm_err === e.fe, "R8 rx_frm_err", int'(rx_frm_err), int'(e.fe));
                    chk(rx_break === e.brk, "R8 rx_break", int'(rx_break), int'(e.brk));
                end
            end
        end
    end

    task automatic send_tx(input logic [7:0] d);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tx_idle();
        while (tx_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input bit flip, input bit stop_lo, input bit expect_it);
        int      bits[$];
        rx_exp_t e;
        int      n;
        logic [7:0] m;
        n = 8 - int'(cfg_len);
        build(d, cfg_len, cfg_par_en, cfg_par_odd, cfg_stop == 2'd1, flip, stop_lo);
        bits = fb;
        m     = d & (8'hFF >> (8 - n));
        e.d   = m;
        e.pe  = cfg_par_en && flip;
        e.fe  = stop_lo;
        e.brk = stop_lo && (m == 8'h00);
        if (expect_it) rxq.push_back(e);
        foreach (bits[i]) begin
            rx_line = bits[i][0];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic odd, input logic [1:0] st);
        cfg_len = l; cfg_par_en = pe; cfg_par_odd = odd; cfg_stop = st;
    endtask

    initial begin
        int nrx;
        // R11: reset state
        repeat (4) @(negedge clk);
        chk(tx_line === 1'b1, "R11 tx_line in reset", int'(tx_line), 1);
        chk(tx_busy === 1'b0, "R11 tx_busy in reset", int'(tx_busy), 0);
        chk(rx_valid === 1'b0, "R11 rx_valid in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1 && !tx_busy && !rx_valid, "R11 after reset",
            int'({tx_line, tx_busy, rx_valid}), 4);
        chk(tx_ready === 1'b1, "R4 ready after reset", int'(tx_ready), 1);
        repeat (2 * BIT_CLKS) @(negedge clk);

        // R1 R4: 8 bits, no parity, one stop; then back-to-back bytes
        set_cfg(2'd0, 0, 0, 2'd0);
        send_tx(8'hA5);
        send_tx(8'h3C);
        wait_tx_idle();

        // R3: 7 bits even parity; R2: 6 bits odd parity two stops; 5 bits two stops
        set_cfg(2'd1, 1, 0, 2'd0); send_tx(8'h5B); wait_tx_idle();
        set_cfg(2'd2, 1, 1, 2'd1); send_tx(8'h2E); wait_tx_idle();
        set_cfg(2'd3, 0, 0, 2'd1); send_tx(8'hFF); wait_tx_idle();
        set_cfg(2'd3, 0, 0, 2'd2); send_tx(8'h0A); wait_tx_idle();

        // R4: settings captured at acceptance, changed mid-character
        set_cfg(2'd0, 1, 1, 2'd0);
        send_tx(8'h81);
        set_cfg(2'd3, 0, 0, 2'd1);
        wait_tx_idle();

        // R4: disabled transmitter ignores a held valid
        tx_en = 1'b0; tx_data = 8'h77; tx_valid = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk(tx_line === 1'b1 && !tx_busy, "R4 disabled tx stays idle",
            int'({tx_line, tx_busy}), 2);
        tx_en = 1'b1;
        @(negedge clk);
        while (tx_busy !== 1'b1) @(negedge clk);
        tx_valid = 1'b0;
        // R5: clearing enable mid-character does not stop it
        repeat (3 * BIT_CLKS) @(negedge clk);
        tx_en = 1'b0;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk(tx_busy === 1'b1, "R5 busy after enable cleared", int'(tx_busy), 1);
        wait_tx_idle();
        tx_en = 1'b1;

        // R6 R1: receive in each length, upper bits zero
        set_cfg(2'd0, 0, 0, 2'd0); send_rx(8'hC3, 0, 0, 1);
        set_cfg(2'd1, 0, 0, 2'd0); send_rx(8'hFF, 0, 0, 1);
        set_cfg(2'd2, 1, 0, 2'd1); send_rx(8'hEA, 0, 0, 1);
        set_cfg(2'd3, 1, 1, 2'd0); send_rx(8'hFF, 0, 0, 1);

        // R7: parity errors, even and odd
        set_cfg(2'd0, 1, 0, 2'd0); send_rx(8'h96, 1, 0, 1);
        set_cfg(2'd0, 1, 1, 2'd0); send_rx(8'h01, 1, 0, 1);
        set_cfg(2'd0, 1, 1, 2'd0); send_rx(8'h01, 0, 0, 1);

        // R8: framing error with data, then break (zero data, low stop)
        set_cfg(2'd0, 0, 0, 2'd0); send_rx(8'h5A, 0, 1, 1);
        send_rx(8'h00, 0, 1, 1);
        set_cfg(2'd2, 0, 0, 2'd0); send_rx(8'h40, 0, 1, 1);

        // R9: short start glitch is discarded, then a real character follows
        set_cfg(2'd0, 0, 0, 2'd0);
        nrx = rxq.size();
        rx_line = 1'b0; repeat (4 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
        chk(rxq.size() == nrx, "R9 glitch produced no character", rxq.size(), nrx);
        send_rx(8'h33, 0, 0, 1);

        // R10: disabled receiver delivers nothing; re-enable mid-character
        rx_en = 1'b0;
        send_rx(8'h6D, 0, 0, 0);
        fork
            send_rx(8'h00, 0, 0, 0);
            begin
                repeat (2 * BIT_CLKS) @(negedge clk);
                rx_en = 1'b1;
            end
        join
        send_rx(8'h9E, 0, 0, 1);

        // R4 R6: both directions at once
        set_cfg(2'd1, 1, 0, 2'd1);
        fork
            begin send_tx(8'h44); wait_tx_idle(); end
            send_rx(8'h2B, 0, 0, 1);
        join

        repeat (BIT_CLKS) @(negedge clk);
        chk(rxq.size() == 0, "R6 all expected characters delivered", rxq.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule